// File: doc/BRIEF.md
# Transactional Read/Write Set Conflict Detector

This block follows the memory footprint of one speculative transaction and tells the core when another agent has disturbed it. While a transaction is open, the local port reports each load and store. The block records the touched cache lines in a small fully associative table. Each entry carries a read mark, a write mark and one buffered data word for the line. Stores are kept in the table and go nowhere else until the transaction commits.

A snoop port carries addresses that other agents read or write. A remote write conflicts with any recorded line. A remote read conflicts only with a line that has been written. A conflict, a request from the core, or a full table ends the transaction. The block then raises a one-cycle abort pulse with a cause code and clears everything it recorded. On commit, the buffered lines leave on a drain port in one uninterrupted burst. Snoops are held off until the burst ends.

A store that takes a lock at the start of an elided critical section is flagged as such. It is recorded as a read, so other threads that elide the same lock do not conflict with it.

Top module: `txConflictTop`

## Requirements
- R1: Entries match on the line address, that is the address with its low LINE_OFF bits dropped (default line of 4 bytes). Accesses that differ only in those bits share one entry, and a later store to the line replaces its buffered data.
- R2: A local load inside an open transaction puts its line in the read set, and a later remote write to that line aborts with cause 2'b01.
- R3: A remote read of a line that is only in the read set does not abort. A remote read of a line in the write set aborts with cause 2'b01.
- R4: A local store inside an open transaction puts its line in the write set, and a later remote write to that line aborts with cause 2'b01.
- R5: A local store flagged by locIsLock is recorded in the read set only. A remote read of its line does not abort, a remote write does, and the line is never drained.
- R6: On commit (txEnd), drainValid is high for exactly one cycle per written line, and the cycles are back to back. Lines leave in the order in which they were first touched in the transaction, each with its latest stored data and a line-aligned address. drainLast marks the final line, and snpReady is low for the whole burst, during which snoops cause no abort.
- R7: After any abort, no line written before the abort is ever drained.
- R8: A local access to a new line when all ENTRIES entries are in use aborts with cause 2'b10. An access to a line already held does not abort.
- R9: txAbortReq during an open transaction aborts with cause 2'b11.
- R10: abortPulse is high for exactly one cycle, in the cycle after the triggering input. In that same cycle txActive is low. abortCause is 2'b00 whenever abortPulse is low. txActive rises in the cycle after txStart.
- R11: Local accesses and snoops while no transaction is open change nothing: they cause no abort and are never drained.
- R12: A commit with an empty write set produces no drain cycle and closes the transaction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | Open a transaction (taken when idle) |
| txEnd | input | 1 | Request commit of the open transaction |
| txAbortReq | input | 1 | Request an abort of the open transaction |
| locValid | input | 1 | Local access present |
| locIsWrite | input | 1 | Local access is a store |
| locIsLock | input | 1 | Store takes the elided lock |
| locAddr | input | ADDR_W | Local byte address |
| locData | input | DATA_W | Local store data |
| snpValid | input | 1 | Remote access present |
| snpIsWrite | input | 1 | Remote access is a write |
| snpAddr | input | ADDR_W | Remote byte address |
| snpReady | output | 1 | Snoops are being accepted (low while draining) |
| txActive | output | 1 | A transaction is open |
| abortPulse | output | 1 | One-cycle abort indication |
| abortCause | output | 2 | 01 remote conflict, 10 capacity, 11 requested |
| drainValid | output | 1 | A committed line is on the drain port |
| drainAddr | output | ADDR_W | Line-aligned address of the drained line |
| drainData | output | DATA_W | Buffered data of the drained line |
| drainLast | output | 1 | Final line of the commit burst |

## Verification
A stuck read or write mark only shows up when the matching snoop arrives. A missed abort, or an abort that should not happen, is then visible in the very next cycle. A stale entry left over after a clear, or a lost store, stays hidden until the next commit. It then surfaces as an extra, missing or reordered line, or wrong data, on the drain port. For this reason, every snoop kind is crossed with every way a line can be held, and every table fill level is committed and compared line by line.

// File: rtl/txPkg.sv
package txPkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_REMOTE   = 2'b01,
    CAUSE_CAPACITY = 2'b10,
    CAUSE_EXPLICIT = 2'b11
  } abortCause_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } txState_e;

  // strobes from control to the set table
  typedef struct packed {
    logic clearAll;
    logic applyLocal;
    logic drainPop;
  } tblStrobe_t;

  // status from the set table to control
  typedef struct packed {
    logic locHit;
    logic full;
    logic snpConflict;
    logic wrEmpty;
    logic drainLast;
  } tblStatus_t;
endpackage

// File: rtl/txSetTable.sv
module txSetTable
  import txPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LINE_OFF = 2,
  parameter int ENTRIES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic              locIsWrite,
  input  logic              locIsLock,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locData,
  input  logic              snpIsWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output tblStatus_t        status,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData
);
  localparam int TAG_W = ADDR_W - LINE_OFF;
  localparam logic [ENTRIES-1:0] ONE_V = ENTRIES'(1);

  logic [ENTRIES-1:0] entValid, entRd, entWr;
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [DATA_W-1:0]  entData [ENTRIES];

  logic [TAG_W-1:0]   locTag, snpTag, drainTag;
  logic [ENTRIES-1:0] locMatch, snpMatch, freeVec, freeOne;
  logic [ENTRIES-1:0] wrMask, drainOne, writeSel;
  logic               storeData, anyLocHit;

  assign locTag    = locAddr[ADDR_W-1:LINE_OFF];
  assign snpTag    = snpAddr[ADDR_W-1:LINE_OFF];
  assign storeData = locIsWrite & ~locIsLock;

  for (genvar i = 0; i < ENTRIES; i++) begin : gMatch
    assign locMatch[i] = entValid[i] && (entTag[i] == locTag);
    assign snpMatch[i] = entValid[i] && (entTag[i] == snpTag);
  end

  // lowest free slot and lowest pending written slot, isolated as one-hot
  assign freeVec   = ~entValid;
  assign freeOne   = freeVec & (~freeVec + ONE_V);
  assign wrMask    = entWr & entValid;
  assign drainOne  = wrMask & (~wrMask + ONE_V);
  assign anyLocHit = |locMatch;
  assign writeSel  = strobe.applyLocal ? (anyLocHit ? locMatch : freeOne) : '0;

  always_comb begin
    status.locHit      = anyLocHit;
    status.full        = &entValid;
    status.snpConflict = snpIsWrite ? |(snpMatch & (entRd | entWr))
                                    : |(snpMatch & entWr);
    status.wrEmpty     = ~|wrMask;
    status.drainLast   = (|wrMask) && ((wrMask & (wrMask - ONE_V)) == '0);
  end

  always_comb begin
    drainTag  = '0;
    drainData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (drainOne[i]) begin
        drainTag  = drainTag | entTag[i];
        drainData = drainData | entData[i];
      end
    end
  end

  assign drainAddr = {drainTag, {LINE_OFF{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entRd    <= '0;
      entWr    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entTag[i]  <= '0;
        entData[i] <= '0;
      end
    end else if (strobe.clearAll) begin
      entValid <= '0;
      entRd    <= '0;
      entWr    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (writeSel[i]) begin
          entValid[i] <= 1'b1;
          entTag[i]   <= locTag;
          if (storeData) begin
            entWr[i]   <= 1'b1;
            entData[i] <= locData;
          end else begin
            entRd[i] <= 1'b1;
          end
        end else if (strobe.drainPop && drainOne[i]) begin
          entWr[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/txCtrl.sv
module txCtrl
  import txPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       txEnd,
  input  logic       txAbortReq,
  input  logic       locValid,
  input  logic       snpValid,
  input  tblStatus_t status,
  output tblStrobe_t strobe,
  output txState_e   state,
  output logic       abortPulse,
  output logic [1:0] abortCause
);
  txState_e    nextState;
  logic        abortNow;
  abortCause_e causeNow;

  always_comb begin
    strobe    = '0;
    nextState = state;
    abortNow  = 1'b0;
    causeNow  = CAUSE_NONE;
    case (state)
      ST_IDLE: begin
        if (txStart) nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (snpValid && status.snpConflict) begin
          abortNow = 1'b1;
          causeNow = CAUSE_REMOTE;
        end else if (txAbortReq) begin
          abortNow = 1'b1;
          causeNow = CAUSE_EXPLICIT;
        end else if (txEnd) begin
          if (status.wrEmpty) begin
            strobe.clearAll = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            nextState = ST_DRAIN;
          end
        end else if (locValid && !status.locHit && status.full) begin
          abortNow = 1'b1;
          causeNow = CAUSE_CAPACITY;
        end else if (locValid) begin
          strobe.applyLocal = 1'b1;
        end
        if (abortNow) begin
          strobe.clearAll = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        strobe.drainPop = 1'b1;
        if (status.drainLast) begin
          strobe.clearAll = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      abortPulse <= 1'b0;
      abortCause <= CAUSE_NONE;
    end else begin
      state      <= nextState;
      abortPulse <= abortNow;
      abortCause <= causeNow;
    end
  end
endmodule

// File: rtl/txConflictTop.sv
module txConflictTop
  import txPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LINE_OFF = 2,
  parameter int ENTRIES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic              txEnd,
  input  logic              txAbortReq,
  input  logic              locValid,
  input  logic              locIsWrite,
  input  logic              locIsLock,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locData,
  input  logic              snpValid,
  input  logic              snpIsWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpReady,
  output logic              txActive,
  output logic              abortPulse,
  output logic [1:0]        abortCause,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic              drainLast
);
  tblStrobe_t strobe;
  tblStatus_t status;
  txState_e   state;

  txCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txEnd(txEnd),
    .txAbortReq(txAbortReq), .locValid(locValid), .snpValid(snpValid),
    .status(status), .strobe(strobe), .state(state),
    .abortPulse(abortPulse), .abortCause(abortCause)
  );

  txSetTable #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFF(LINE_OFF), .ENTRIES(ENTRIES)
  ) table_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .locIsWrite(locIsWrite), .locIsLock(locIsLock),
    .locAddr(locAddr), .locData(locData),
    .snpIsWrite(snpIsWrite), .snpAddr(snpAddr),
    .status(status), .drainAddr(drainAddr), .drainData(drainData)
  );

  assign txActive   = (state == ST_ACTIVE);
  assign drainValid = (state == ST_DRAIN);
  assign snpReady   = (state != ST_DRAIN);
  assign drainLast  = drainValid & status.drainLast;
endmodule

// File: rtl/txConflictChecker.sv
module txConflictChecker (
  input logic       clk,
  input logic       rstN,
  input logic       txAbortReq,
  input logic       snpValid,
  input logic       snpReady,
  input logic       txActive,
  input logic       abortPulse,
  input logic [1:0] abortCause,
  input logic       drainValid,
  input logic       drainLast
);
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);
  assert_closed_on_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !txActive);
  assert_cause_when_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> abortCause != 2'b00);
  assert_cause_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !abortPulse |-> abortCause == 2'b00);
  assert_remote_needs_snoop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse && abortCause == 2'b01) |-> $past(snpValid && snpReady));
  assert_explicit_needs_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse && abortCause == 2'b11) |-> $past(txAbortReq));
  assert_drain_blocks_snoop_R6: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> (!snpReady && !txActive));
  assert_drain_back_to_back_R6: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && !drainLast) |=> drainValid);
  assert_drain_ends_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && drainLast) |=> !drainValid);
endmodule

bind txConflictTop txConflictChecker chk_i (
  .clk(clk), .rstN(rstN), .txAbortReq(txAbortReq), .snpValid(snpValid),
  .snpReady(snpReady), .txActive(txActive), .abortPulse(abortPulse),
  .abortCause(abortCause), .drainValid(drainValid), .drainLast(drainLast)
);

// File: tb/txConflictTop_tb_top.sv
`timescale 1ns/100ps
module txConflictTop_tb_top;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int OFF = 2;
  localparam int ENT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 0, txEnd = 0, txAbortReq = 0;
  logic locValid = 0, locIsWrite = 0, locIsLock = 0;
  logic [AW-1:0] locAddr = '0;
  logic [DW-1:0] locData = '0;
  logic snpValid = 0, snpIsWrite = 0;
  logic [AW-1:0] snpAddr = '0;
  logic snpReady, txActive, abortPulse, drainValid, drainLast;
  logic [1:0] abortCause;
  logic [AW-1:0] drainAddr;
  logic [DW-1:0] drainData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // model of what the transaction holds, in first-touch order
  int mCount = 0;
  logic [AW-OFF-1:0] mTag [8];
  bit mWr [8];
  logic [DW-1:0] mData [8];

  always #2.5 clk = ~clk;

  txConflictTop #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFF(OFF), .ENTRIES(ENT)) dut_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txEnd(txEnd), .txAbortReq(txAbortReq),
    .locValid(locValid), .locIsWrite(locIsWrite), .locIsLock(locIsLock),
    .locAddr(locAddr), .locData(locData), .snpValid(snpValid), .snpIsWrite(snpIsWrite),
    .snpAddr(snpAddr), .snpReady(snpReady), .txActive(txActive), .abortPulse(abortPulse),
    .abortCause(abortCause), .drainValid(drainValid), .drainAddr(drainAddr),
    .drainData(drainData), .drainLast(drainLast)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void mClear();
    mCount = 0;
    for (int i = 0; i < 8; i++) mWr[i] = 0;
  endfunction

  task automatic doStart();
    txStart = 1;
    tick();
    txStart = 0;
    check(txActive == 1'b1, "R10", "txActive after start", int'(txActive), 1);
    mClear();
  endtask

  task automatic doAccess(input bit wr, input bit lk, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data, input string req);
    int idx;
    bit expAbort;
    logic [AW-OFF-1:0] tag;
    idx = -1;
    tag = addr[AW-1:OFF];
    for (int i = 0; i < mCount; i++) if (mTag[i] == tag) idx = i;
    expAbort = (idx < 0) && (mCount == ENT);
    locValid = 1; locIsWrite = wr; locIsLock = lk; locAddr = addr; locData = data;
    tick();
    locValid = 0; locIsWrite = 0; locIsLock = 0;
    check(abortPulse == expAbort, req, "abort on local access", int'(abortPulse), int'(expAbort));
    if (expAbort) begin
      check(abortCause == 2'b10, "R8", "capacity cause", int'(abortCause), 2);
      check(txActive == 1'b0, "R8", "closed after capacity abort", int'(txActive), 0);
      mClear();
    end else begin
      if (idx < 0) begin
        idx = mCount;
        mTag[idx] = tag;
        mWr[idx] = 0;
        mCount++;
      end
      if (wr && !lk) begin
        mWr[idx] = 1;
        mData[idx] = data;
      end
    end
  endtask

  task automatic doSnoop(input bit wr, input logic [AW-1:0] addr, input bit expA,
                         input string req);
    snpValid = 1; snpIsWrite = wr; snpAddr = addr;
    tick();
    snpValid = 0; snpIsWrite = 0;
    check(abortPulse == expA, req, "abort on snoop", int'(abortPulse), int'(expA));
    if (expA) begin
      check(abortCause == 2'b01, req, "remote cause", int'(abortCause), 1);
      check(txActive == 1'b0, "R10", "closed on abort", int'(txActive), 0);
      mClear();
      tick();
      check(abortPulse == 1'b0, "R10", "pulse width", int'(abortPulse), 0);
      check(abortCause == 2'b00, "R10", "cause idle", int'(abortCause), 0);
    end else begin
      check(txActive == 1'b1, req, "still open", int'(txActive), 1);
    end
  endtask

  task automatic doExplicit();
    txAbortReq = 1;
    tick();
    txAbortReq = 0;
    check(abortPulse == 1'b1, "R9", "requested abort", int'(abortPulse), 1);
    check(abortCause == 2'b11, "R9", "requested cause", int'(abortCause), 3);
    check(txActive == 1'b0, "R10", "closed on abort", int'(txActive), 0);
    mClear();
    tick();
    check(abortPulse == 1'b0, "R10", "pulse width", int'(abortPulse), 0);
  endtask

  task automatic doCommit(input string req, input bit snoopDuring);
    int expN;
    int n;
    int k;
    expN = 0; n = 0; k = 0;
    for (int i = 0; i < mCount; i++) if (mWr[i]) expN++;
    txEnd = 1;
    tick();
    txEnd = 0;
    check(txActive == 1'b0, req, "closed at commit", int'(txActive), 0);
    while (drainValid && n < 16) begin
      while (k < mCount && !mWr[k]) k++;
      if (k < mCount) begin
        check(drainAddr == {mTag[k], {OFF{1'b0}}}, req, "drain address",
              int'(drainAddr), int'({mTag[k], {OFF{1'b0}}}));
        check(drainData == mData[k], req, "drain data", int'(drainData), int'(mData[k]));
      end else begin
        check(1'b0, req, "unexpected drained line", int'(drainAddr), -1);
      end
      check(drainLast == (n == expN - 1), "R6", "last flag", int'(drainLast),
            int'(n == expN - 1));
      check(snpReady == 1'b0, "R6", "snoops held off", int'(snpReady), 0);
      if (snoopDuring) begin
        snpValid = 1; snpIsWrite = 1; snpAddr = drainAddr;
      end
      k++; n++;
      tick();
      snpValid = 0; snpIsWrite = 0;
      check(abortPulse == 1'b0, "R6", "no abort in drain", int'(abortPulse), 0);
    end
    check(n == expN, req, "drained line count", n, expN);
    check(drainValid == 1'b0, req, "drain finished", int'(drainValid), 0);
    mClear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // reset state
    check(txActive == 1'b0, "R10", "reset txActive", int'(txActive), 0);
    check(abortPulse == 1'b0, "R10", "reset abortPulse", int'(abortPulse), 0);
    check(drainValid == 1'b0, "R6", "reset drainValid", int'(drainValid), 0);
    check(snpReady == 1'b1, "R6", "reset snpReady", int'(snpReady), 1);

    // R11: idle traffic leaves no trace
    locValid = 1; locIsWrite = 1; locAddr = 16'h0200; locData = 16'hDEAD;
    snpValid = 1; snpIsWrite = 1; snpAddr = 16'h0200;
    tick();
    locValid = 0; locIsWrite = 0; snpValid = 0; snpIsWrite = 0;
    check(abortPulse == 1'b0, "R11", "idle snoop abort", int'(abortPulse), 0);
    check(txActive == 1'b0, "R11", "idle stays idle", int'(txActive), 0);
    doStart();
    doAccess(1, 0, 16'h0300, 16'h3333, "R4");
    doCommit("R11", 0);

    // R1: sub-line offsets share an entry
    doStart();
    doAccess(1, 0, 16'h0010, 16'hAAAA, "R1");
    doAccess(1, 0, 16'h0013, 16'hBBBB, "R1");
    doCommit("R1", 0);
    doStart();
    doAccess(0, 0, 16'h0030, 16'h0000, "R1");
    doSnoop(1, 16'h0031, 1, "R1");

    // sweep: how the line is held x snoop kind x same or other line
    for (int kind = 0; kind < 4; kind++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int same = 0; same < 2; same++) begin
          bit expA;
          string lbl;
          doStart();
          if (kind == 1) doAccess(0, 0, 16'h0020, 16'h0000, "R2");
          if (kind == 2) doAccess(1, 0, 16'h0020, 16'h5A5A, "R4");
          if (kind == 3) doAccess(1, 1, 16'h0020, 16'h1111, "R5");
          expA = (same == 1) && ((sw == 1) ? (kind != 0) : (kind == 2));
          lbl = (kind == 3) ? "R5" : (kind == 1) ? "R2" : (sw == 1) ? "R4" : "R3";
          doSnoop(sw[0], (same == 1) ? 16'h0022 : 16'h0044, expA, lbl);
          if (!expA) doExplicit();
        end
      end
    end

    // R5: lock line never drained
    doStart();
    doAccess(1, 1, 16'h0700, 16'h7777, "R5");
    doAccess(1, 0, 16'h0710, 16'h7171, "R5");
    doCommit("R5", 0);

    // capacity sweep over every fill level
    for (int n = 1; n <= ENT + 1; n++) begin
      doStart();
      for (int j = 0; j < n; j++)
        doAccess(1, 0, 16'(16'h0100 + j * 16), 16'(16'hC000 + n * 16 + j), "R8");
      if (n <= ENT) begin
        if (n == ENT) doAccess(0, 0, 16'h0101, 16'h0000, "R8");
        doCommit("R6", 1);
      end else begin
        doStart();
        doCommit("R7", 0);
      end
    end

    // R6: order is first touch, including lines read before written
    doStart();
    doAccess(0, 0, 16'h0400, 16'h0000, "R6");
    doAccess(1, 0, 16'h0410, 16'h4101, "R6");
    doAccess(1, 0, 16'h0400, 16'h4002, "R6");
    doAccess(0, 0, 16'h0420, 16'h0000, "R6");
    doSnoop(0, 16'h0420, 0, "R3");
    doAccess(1, 0, 16'h0430, 16'h4303, "R6");
    doCommit("R6", 1);

    // R7: aborted stores vanish
    doStart();
    doAccess(1, 0, 16'h0500, 16'h5050, "R7");
    doAccess(1, 0, 16'h0510, 16'h5151, "R7");
    doExplicit();
    doStart();
    doAccess(1, 0, 16'h0520, 16'h5252, "R7");
    doCommit("R7", 0);

    // R12: read-only commit
    doStart();
    doAccess(0, 0, 16'h0600, 16'h0000, "R12");
    doCommit("R12", 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule